// File: doc/BRIEF.md
# Multi-Mode Encoder Phase Counter Pair

This block holds two counter channels that follow incremental-encoder phase signals. Each channel picks one of three counting functions from a small mode field: full-resolution quadrature (every edge of both phases), step-and-direction (step on one phase's rising edge, direction from the other phase's level), or half-resolution quadrature that reacts only to the second phase. Every count has a programmable ceiling. Counting down below zero reloads the ceiling. An optional clear-on-match returns an upward count to zero once it has reached the ceiling.

A shared configuration register joins the two 16-bit counts into one 32-bit count. In that mode the low half is the first channel and the high half is the second channel. The joined count uses its own 32-bit ceiling and takes its function and clear setting from the first channel. The same register chooses which external phase pair feeds the second channel and the joined count. The first channel always listens to the first pair. All phase pins are asynchronous and are resynchronised inside the block. Software reaches every setting through a flat register bus with single-cycle writes and combinational reads.

Top module: `phc_counter`

## Requirements
- R1: After reset both mode fields read 4, both clear bits read 0, both counts read 0, both 16-bit ceilings read 0xFFFF, the 32-bit ceiling reads 0xFFFFFFFF, the shared register reads 0 and both status registers read 0x80.
- R2: With mode 4 the count moves one step on every edge of either phase. It counts up when the phase pair advances 00→10→11→01→00 (written as A,B) and down in the reverse order. A sample in which both phases change at once leaves the count unchanged.
- R3: With mode 5 only a rising edge of phase A moves the count: up when phase B is high, down when it is low. Falling A edges and all B edges have no effect.
- R4: With mode 7 a change of phase B while phase A is steady moves the count, with the direction of the R2 sequence. Edges of phase A never move the count.
- R5: A mode value other than 4, 5 or 7 holds the count whatever the phases do.
- R6: Bit 7 of a channel's status register shows the direction of that channel's most recent step: 1 for up, 0 for down.
- R7: With bit 0 of a channel's control register set, an up step taken while the count equals the ceiling gives 0. With the bit clear, an up step always adds one and wraps from all-ones to 0 at full width, even past the ceiling.
- R8: A down step taken from a count of 0 loads the ceiling.
- R9: Bit 0 of the shared register joins the channels into one 32-bit count, read and written at the long count address (address 11). The high half changes only on a carry or borrow out of the low half. While joined, writes to the 16-bit count addresses are ignored. While separate, writes to the long count address are ignored.
- R10: Bit 1 of the shared register feeds the second channel and the joined count from phases C/D when 1 and from A/B when 0. The first channel always uses A/B.
- R11: A phase change first sampled at some clock edge shows in the count after the second clock edge that follows it.
- R12: Register addresses: 0 mode 1 (bits 3:0), 1 control 1 (bit 0), 2 status 1, 3 count 1, 4 ceiling 1, 5 mode 2, 6 control 2, 7 status 2, 8 count 2, 9 ceiling 2, 10 shared (bit 0 join, bit 1 pair select), 11 long count, 12 long ceiling. Writable fields read back what was written. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one write per cycle |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Write data (2*HW bits) |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| enc_a | input | 1 | Phase A, first pair |
| enc_b | input | 1 | Phase B, first pair |
| enc_c | input | 1 | Phase A of the second pair |
| enc_d | input | 1 | Phase B of the second pair |

## Verification
The properties assume each phase pin changes at most once per synchronised sample window. They also assume that register writes do not coincide with the cycles they reason about, so a write never hides a step. The carry property is only claimed while the 32-bit ceiling is all ones, because a reload to a smaller ceiling legitimately moves the high half. The stimulus holds every phase level for four clocks, never changes a phase and a register in the same cycle, and changes both phases together only in the one case meant to exercise the simultaneous-change rule.

// File: rtl/phc_pkg.sv
package phc_pkg;
   localparam int PHC_AW = 4;
   localparam int PHC_MW = 4;

   localparam logic [PHC_MW-1:0] MD_QUAD4     = 4'd4;
   localparam logic [PHC_MW-1:0] MD_PULSE_DIR = 4'd5;
   localparam logic [PHC_MW-1:0] MD_QUAD2B    = 4'd7;

   localparam logic [PHC_AW-1:0] A_MODE1  = 4'd0;
   localparam logic [PHC_AW-1:0] A_CTL1   = 4'd1;
   localparam logic [PHC_AW-1:0] A_STAT1  = 4'd2;
   localparam logic [PHC_AW-1:0] A_CNT1   = 4'd3;
   localparam logic [PHC_AW-1:0] A_CEIL1  = 4'd4;
   localparam logic [PHC_AW-1:0] A_MODE2  = 4'd5;
   localparam logic [PHC_AW-1:0] A_CTL2   = 4'd6;
   localparam logic [PHC_AW-1:0] A_STAT2  = 4'd7;
   localparam logic [PHC_AW-1:0] A_CNT2   = 4'd8;
   localparam logic [PHC_AW-1:0] A_CEIL2  = 4'd9;
   localparam logic [PHC_AW-1:0] A_SHARED = 4'd10;
   localparam logic [PHC_AW-1:0] A_LCNT   = 4'd11;
   localparam logic [PHC_AW-1:0] A_LCEIL  = 4'd12;

   typedef struct packed {
      logic step;
      logic up;
   } phc_step_t;
endpackage

// File: rtl/phc_sync.sv
module phc_sync #(
   parameter int N      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] din,
   output logic [N-1:0] cur,
   output logic [N-1:0] prv
);
   if (STAGES < 2) begin : g_bad_stages
      $error("phc_sync needs at least two stages");
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[STAGES-2:0], din[i]};
      end
      assign cur[i] = chain[STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prv <= '0;
      else        prv <= cur;
   end
endmodule

// File: rtl/phc_step_dec.sv
module phc_step_dec
   import phc_pkg::*;
(
   input  logic [PHC_MW-1:0] mode,
   input  logic              a_cur,
   input  logic              a_prv,
   input  logic              b_cur,
   input  logic              b_prv,
   output phc_step_t         st
);
   logic a_chg, b_chg, quad_up;

   always_comb begin
      a_chg   = a_cur ^ a_prv;
      b_chg   = b_cur ^ b_prv;
      quad_up = a_cur ^ b_prv;
      st      = '0;
      case (mode)
         MD_QUAD4: begin
            st.step = a_chg ^ b_chg;
            st.up   = quad_up;
         end
         MD_PULSE_DIR: begin
            st.step = a_cur & ~a_prv;
            st.up   = b_cur;
         end
         MD_QUAD2B: begin
            st.step = b_chg & ~a_chg;
            st.up   = quad_up;
         end
         default: st = '0;
      endcase
   end
endmodule

// File: rtl/phc_count_next.sv
module phc_count_next #(
   parameter int W = 16
) (
   input  logic [W-1:0] cur,
   input  logic [W-1:0] ceil,
   input  logic         up,
   input  logic         clr_en,
   output logic [W-1:0] nxt
);
   always_comb begin
      if (up) nxt = (clr_en && (cur == ceil)) ? '0 : cur + 1'b1;
      else    nxt = (cur == '0) ? ceil : cur - 1'b1;
   end
endmodule

// File: rtl/phc_counter.sv
module phc_counter
   import phc_pkg::*;
#(
   parameter int HW          = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_wr,
   input  logic [PHC_AW-1:0]   bus_addr,
   input  logic [2*HW-1:0]     bus_wdata,
   output logic [2*HW-1:0]     bus_rdata,
   input  logic                enc_a,
   input  logic                enc_b,
   input  logic                enc_c,
   input  logic                enc_d
);
   localparam int LW   = 2 * HW;
   localparam int NPH  = 4;
   localparam int NDEC = 3;

   if (HW < 8) begin : g_bad_width
      $error("phc_counter needs HW of at least 8 for the status bit");
   end

   // synchronised phases: bit 0 A, 1 B, 2 C, 3 D
   logic [NPH-1:0] s_cur, s_prv;
   phc_sync #(.N(NPH), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk), .rst_n(rst_n),
      .din ({enc_d, enc_c, enc_b, enc_a}),
      .cur (s_cur), .prv(s_prv)
   );

   // register state
   logic [PHC_MW-1:0] mode_q [2];
   logic [1:0]        clr_q;
   logic [HW-1:0]     cnt_q  [2];
   logic [HW-1:0]     ceil_q [2];
   logic [1:0]        dir_q;
   logic [1:0]        shared_q;
   logic [LW-1:0]     ceil_l_q;

   logic cascade, pair_sel;
   assign cascade  = shared_q[0];
   assign pair_sel = shared_q[1];

   // phase routing for the three decoders: ch1, ch2, joined
   logic ch1_a_cur, ch1_a_prv, ch1_b_cur, ch1_b_prv;
   logic sel_a_cur, sel_a_prv, sel_b_cur, sel_b_prv;
   assign ch1_a_cur = s_cur[0];
   assign ch1_a_prv = s_prv[0];
   assign ch1_b_cur = s_cur[1];
   assign ch1_b_prv = s_prv[1];
   assign sel_a_cur = pair_sel ? s_cur[2] : s_cur[0];
   assign sel_a_prv = pair_sel ? s_prv[2] : s_prv[0];
   assign sel_b_cur = pair_sel ? s_cur[3] : s_cur[1];
   assign sel_b_prv = pair_sel ? s_prv[3] : s_prv[1];

   logic [NDEC-1:0]   dec_ac, dec_ap, dec_bc, dec_bp;
   logic [PHC_MW-1:0] dec_mode [NDEC];
   phc_step_t         dec_st   [NDEC];

   assign dec_ac      = {sel_a_cur, sel_a_cur, ch1_a_cur};
   assign dec_ap      = {sel_a_prv, sel_a_prv, ch1_a_prv};
   assign dec_bc      = {sel_b_cur, sel_b_cur, ch1_b_cur};
   assign dec_bp      = {sel_b_prv, sel_b_prv, ch1_b_prv};
   assign dec_mode[0] = mode_q[0];
   assign dec_mode[1] = mode_q[1];
   assign dec_mode[2] = mode_q[0];

   for (genvar d = 0; d < NDEC; d++) begin : g_dec
      phc_step_dec u_dec (
         .mode (dec_mode[d]),
         .a_cur(dec_ac[d]), .a_prv(dec_ap[d]),
         .b_cur(dec_bc[d]), .b_prv(dec_bp[d]),
         .st   (dec_st[d])
      );
   end

   // next-count arithmetic
   logic [HW-1:0] nxt16 [2];
   logic [LW-1:0] nxt32;
   logic          ch1_step, ch1_up;
   assign ch1_step = dec_st[0].step;
   assign ch1_up   = dec_st[0].up;

   for (genvar c = 0; c < 2; c++) begin : g_half
      phc_count_next #(.W(HW)) u_next (
         .cur   (cnt_q[c]),
         .ceil  (ceil_q[c]),
         .up    (dec_st[c].up),
         .clr_en(clr_q[c]),
         .nxt   (nxt16[c])
      );
   end

   phc_count_next #(.W(LW)) u_next_long (
      .cur   ({cnt_q[1], cnt_q[0]}),
      .ceil  (ceil_l_q),
      .up    (dec_st[2].up),
      .clr_en(clr_q[0]),
      .nxt   (nxt32)
   );

   // state update; a bus write in the same cycle wins over a step
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q[0] <= MD_QUAD4;
         mode_q[1] <= MD_QUAD4;
         clr_q     <= '0;
         cnt_q[0]  <= '0;
         cnt_q[1]  <= '0;
         ceil_q[0] <= '1;
         ceil_q[1] <= '1;
         dir_q     <= '1;
         shared_q  <= '0;
         ceil_l_q  <= '1;
      end else begin
         if (cascade) begin
            if (dec_st[2].step) begin
               cnt_q[0] <= nxt32[HW-1:0];
               cnt_q[1] <= nxt32[LW-1:HW];
               dir_q    <= {2{dec_st[2].up}};
            end
         end else begin
            for (int k = 0; k < 2; k++) begin
               if (dec_st[k].step) begin
                  cnt_q[k] <= nxt16[k];
                  dir_q[k] <= dec_st[k].up;
               end
            end
         end

         if (bus_wr) begin
            case (bus_addr)
               A_MODE1:  mode_q[0] <= bus_wdata[PHC_MW-1:0];
               A_CTL1:   clr_q[0]  <= bus_wdata[0];
               A_CNT1:   if (!cascade) cnt_q[0] <= bus_wdata[HW-1:0];
               A_CEIL1:  ceil_q[0] <= bus_wdata[HW-1:0];
               A_MODE2:  mode_q[1] <= bus_wdata[PHC_MW-1:0];
               A_CTL2:   clr_q[1]  <= bus_wdata[0];
               A_CNT2:   if (!cascade) cnt_q[1] <= bus_wdata[HW-1:0];
               A_CEIL2:  ceil_q[1] <= bus_wdata[HW-1:0];
               A_SHARED: shared_q  <= bus_wdata[1:0];
               A_LCNT: begin
                  if (cascade) begin
                     cnt_q[0] <= bus_wdata[HW-1:0];
                     cnt_q[1] <= bus_wdata[LW-1:HW];
                  end
               end
               A_LCEIL:  ceil_l_q  <= bus_wdata;
               default: ;
            endcase
         end
      end
   end

   // read mux
   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         A_MODE1:  bus_rdata[PHC_MW-1:0] = mode_q[0];
         A_CTL1:   bus_rdata[0]          = clr_q[0];
         A_STAT1:  bus_rdata[7]          = dir_q[0];
         A_CNT1:   bus_rdata[HW-1:0]     = cnt_q[0];
         A_CEIL1:  bus_rdata[HW-1:0]     = ceil_q[0];
         A_MODE2:  bus_rdata[PHC_MW-1:0] = mode_q[1];
         A_CTL2:   bus_rdata[0]          = clr_q[1];
         A_STAT2:  bus_rdata[7]          = dir_q[1];
         A_CNT2:   bus_rdata[HW-1:0]     = cnt_q[1];
         A_CEIL2:  bus_rdata[HW-1:0]     = ceil_q[1];
         A_SHARED: bus_rdata[1:0]        = shared_q;
         A_LCNT:   bus_rdata             = {cnt_q[1], cnt_q[0]};
         A_LCEIL:  bus_rdata             = ceil_l_q;
         default:  bus_rdata             = '0;
      endcase
   end
endmodule

// File: rtl/phc_checker.sv
module phc_checker
   import phc_pkg::*;
#(
   parameter int HW = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic              casc,
   input logic [PHC_MW-1:0] mode1,
   input logic              a_cur,
   input logic              a_prv,
   input logic              b_cur,
   input logic              b_prv,
   input logic              st1_step,
   input logic              st1_up,
   input logic [HW-1:0]     cnt1,
   input logic [HW-1:0]     cnt2,
   input logic [2*HW-1:0]   ceil_l,
   input logic              dir1
);
   p_simul_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode1 == MD_QUAD4 && a_cur != a_prv && b_cur != b_prv) |-> !st1_step);

   p_pdir_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode1 == MD_PULSE_DIR && !(a_cur && !a_prv)) |-> !st1_step);

   p_x2b_ignore_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode1 == MD_QUAD2B && a_cur != a_prv) |-> !st1_step);

   p_bad_mode_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!casc && !bus_wr && mode1 != MD_QUAD4 && mode1 != MD_PULSE_DIR &&
       mode1 != MD_QUAD2B) |=> $stable(cnt1));

   p_dir_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!casc && st1_step) |=> (dir1 == $past(st1_up)));

   p_carry_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (casc && !bus_wr && ceil_l == '1) |=>
         ((cnt2 == $past(cnt2)) ||
          ($past(cnt1) == '1 && cnt1 == '0) ||
          ($past(cnt1) == '0 && cnt1 == '1)));
endmodule

bind phc_counter phc_checker #(.HW(HW)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .bus_wr  (bus_wr),
   .casc    (cascade),
   .mode1   (mode_q[0]),
   .a_cur   (ch1_a_cur),
   .a_prv   (ch1_a_prv),
   .b_cur   (ch1_b_cur),
   .b_prv   (ch1_b_prv),
   .st1_step(ch1_step),
   .st1_up  (ch1_up),
   .cnt1    (cnt_q[0]),
   .cnt2    (cnt_q[1]),
   .ceil_l  (ceil_l_q),
   .dir1    (dir_q[0])
);

// File: tb/sim_phc_counter.sv
module sim_phc_counter;
   import phc_pkg::*;

   localparam int HW = 16;
   localparam int LW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic [3:0]    bus_addr = '0;
   logic [LW-1:0] bus_wdata = '0;
   logic [LW-1:0] bus_rdata;
   logic          enc_a = 1'b0, enc_b = 1'b0, enc_c = 1'b0, enc_d = 1'b0;

   always #2 clk = ~clk;

   phc_counter #(.HW(HW)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .enc_a(enc_a), .enc_b(enc_b), .enc_c(enc_c), .enc_d(enc_d)
   );

   int    n_chk = 0;
   int    n_err = 0;
   bit    done  = 0;
   string cur_tag = "R1";

   task automatic check(string tag, logic [LW-1:0] got, logic [LW-1:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s: got 0x%08h expected 0x%08h at %0t", tag, got, exp, $time);
      end
   endtask

   // ---------------- reference model ----------------
   logic [3:0]  m_mode [2];
   bit          m_clr  [2];
   longint unsigned m_cnt [2];
   longint unsigned m_ceil[2];
   bit          m_dir  [2];
   logic [1:0]  m_shr;
   longint unsigned m_ceill;
   logic [3:0]  h0, h1, h2;

   function automatic int qpos(logic a, logic b);
      case ({a, b})
         2'b00:   return 0;
         2'b10:   return 1;
         2'b11:   return 2;
         default: return 3;
      endcase
   endfunction

   function automatic int m_step(logic [3:0] md, logic ac, logic ap, logic bc, logic bp);
      int d;
      d = (qpos(ac, bc) - qpos(ap, bp) + 4) % 4;
      if (md == 4) return (d == 1) ? 1 : (d == 3) ? -1 : 0;
      if (md == 5) return (ac && !ap) ? (bc ? 1 : -1) : 0;
      if (md == 7) return (ac == ap && bc != bp) ? ((d == 1) ? 1 : -1) : 0;
      return 0;
   endfunction

   function automatic longint unsigned m_move(longint unsigned v, int s,
                                              longint unsigned ceil, bit clr, int w);
      if (s > 0) begin
         if (clr && v == ceil) return 0;
         return (v + 1) % (64'd1 << w);
      end
      if (v == 0) return ceil;
      return v - 1;
   endfunction

   function automatic logic [LW-1:0] exp_read(logic [3:0] a);
      case (a)
         A_MODE1:  return {28'd0, m_mode[0]};
         A_CTL1:   return {31'd0, m_clr[0]};
         A_STAT1:  return {24'd0, m_dir[0], 7'd0};
         A_CNT1:   return m_cnt[0][LW-1:0];
         A_CEIL1:  return m_ceil[0][LW-1:0];
         A_MODE2:  return {28'd0, m_mode[1]};
         A_CTL2:   return {31'd0, m_clr[1]};
         A_STAT2:  return {24'd0, m_dir[1], 7'd0};
         A_CNT2:   return m_cnt[1][LW-1:0];
         A_CEIL2:  return m_ceil[1][LW-1:0];
         A_SHARED: return {30'd0, m_shr};
         A_LCNT:   return m_cnt[0][LW-1:0] | (m_cnt[1][LW-1:0] << HW);
         A_LCEIL:  return m_ceill[LW-1:0];
         default:  return '0;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < 2; k++) begin
            m_mode[k] = 4'd4; m_clr[k] = 0; m_cnt[k] = 0;
            m_ceil[k] = 64'hFFFF; m_dir[k] = 1;
         end
         m_shr = 0; m_ceill = 64'hFFFF_FFFF;
         h0 = 0; h1 = 0; h2 = 0;
      end else begin
         logic sa_c, sa_p, sb_c, sb_p;
         int s;
         longint unsigned lv;
         sa_c = m_shr[1] ? h1[2] : h1[0];
         sa_p = m_shr[1] ? h2[2] : h2[0];
         sb_c = m_shr[1] ? h1[3] : h1[1];
         sb_p = m_shr[1] ? h2[3] : h2[1];
         if (m_shr[0]) begin
            s = m_step(m_mode[0], sa_c, sa_p, sb_c, sb_p);
            if (s != 0) begin
               lv = m_cnt[0] + (m_cnt[1] << HW);
               lv = m_move(lv, s, m_ceill, m_clr[0], LW);
               m_cnt[0] = lv & 64'hFFFF;
               m_cnt[1] = lv >> HW;
               m_dir[0] = (s > 0); m_dir[1] = (s > 0);
            end
         end else begin
            s = m_step(m_mode[0], h1[0], h2[0], h1[1], h2[1]);
            if (s != 0) begin
               m_cnt[0] = m_move(m_cnt[0], s, m_ceil[0], m_clr[0], HW);
               m_dir[0] = (s > 0);
            end
            s = m_step(m_mode[1], sa_c, sa_p, sb_c, sb_p);
            if (s != 0) begin
               m_cnt[1] = m_move(m_cnt[1], s, m_ceil[1], m_clr[1], HW);
               m_dir[1] = (s > 0);
            end
         end
         if (bus_wr) begin
            case (bus_addr)
               A_MODE1:  m_mode[0] = bus_wdata[3:0];
               A_CTL1:   m_clr[0]  = bus_wdata[0];
               A_CNT1:   if (!m_shr[0]) m_cnt[0] = bus_wdata[15:0];
               A_CEIL1:  m_ceil[0] = bus_wdata[15:0];
               A_MODE2:  m_mode[1] = bus_wdata[3:0];
               A_CTL2:   m_clr[1]  = bus_wdata[0];
               A_CNT2:   if (!m_shr[0]) m_cnt[1] = bus_wdata[15:0];
               A_CEIL2:  m_ceil[1] = bus_wdata[15:0];
               A_SHARED: m_shr     = bus_wdata[1:0];
               A_LCNT:   if (m_shr[0]) begin
                            m_cnt[0] = bus_wdata[15:0];
                            m_cnt[1] = bus_wdata[31:16];
                         end
               A_LCEIL:  m_ceill   = bus_wdata;
               default: ;
            endcase
         end
         h2 = h1; h1 = h0; h0 = {enc_d, enc_c, enc_b, enc_a};
      end
      #1;
      if (rst_n && !done) check({cur_tag, " per-cycle readback"}, bus_rdata, exp_read(bus_addr));
   end

   // ---------------- stimulus helpers ----------------
   task automatic wr(logic [3:0] a, logic [LW-1:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(logic [3:0] a, output logic [LW-1:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic rchk(string tag, logic [3:0] a, logic [LW-1:0] exp);
      logic [LW-1:0] d;
      rd(a, d);
      check(tag, d, exp);
   endtask

   task automatic set_ab(logic a, logic b);
      @(negedge clk);
      enc_a = a; enc_b = b;
      repeat (4) @(negedge clk);
   endtask

   task automatic set_cd(logic c, logic d);
      @(negedge clk);
      enc_c = c; enc_d = d;
      repeat (4) @(negedge clk);
   endtask

   function automatic logic [1:0] pos_bits(int p);
      case (p % 4)
         0:       return 2'b00;
         1:       return 2'b10;
         2:       return 2'b11;
         default: return 2'b01;
      endcase
   endfunction

   task automatic qmove_ab(bit up);
      logic [1:0] nb;
      nb = pos_bits(qpos(enc_a, enc_b) + (up ? 1 : 3));
      set_ab(nb[1], nb[0]);
   endtask

   task automatic qmove_cd(bit up);
      logic [1:0] nb;
      nb = pos_bits(qpos(enc_c, enc_d) + (up ? 1 : 3));
      set_cd(nb[1], nb[0]);
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         done = 1;
         n_err++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      logic [LW-1:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      cur_tag = "R1";
      rchk("R1 mode1", A_MODE1, 32'd4);
      rchk("R1 mode2", A_MODE2, 32'd4);
      rchk("R1 stat1", A_STAT1, 32'h80);
      rchk("R1 cnt1", A_CNT1, 32'd0);
      rchk("R1 ceil1", A_CEIL1, 32'hFFFF);
      rchk("R1 ceil2", A_CEIL2, 32'hFFFF);
      rchk("R1 lceil", A_LCEIL, 32'hFFFF_FFFF);
      rchk("R1 shared", A_SHARED, 32'd0);

      // R2 four-edge quadrature, R6 direction flag
      cur_tag = "R2";
      for (int i = 0; i < 8; i++) qmove_ab(1);
      rchk("R2 up count", A_CNT1, 32'd8);
      rchk("R6 up flag", A_STAT1, 32'h80);
      for (int i = 0; i < 3; i++) qmove_ab(0);
      rchk("R2 down count", A_CNT1, 32'd5);
      rchk("R6 down flag", A_STAT1, 32'h00);
      set_ab(~enc_a, ~enc_b);
      rchk("R2 simultaneous ignored", A_CNT1, 32'd5);

      // R3 pulse/direction (state A=0,B=1)
      cur_tag = "R3";
      wr(A_MODE1, 32'd5);
      wr(A_CNT1, 32'd0);
      set_ab(1, 1);
      set_ab(0, 1);
      set_ab(1, 1);
      rchk("R3 rising A with B high", A_CNT1, 32'd2);
      set_ab(1, 0);
      set_ab(0, 0);
      set_ab(1, 0);
      rchk("R3 rising A with B low", A_CNT1, 32'd1);
      rchk("R6 flag after pulse down", A_STAT1, 32'h00);

      // R4 two-edge on B (state A=1,B=0)
      cur_tag = "R4";
      wr(A_MODE1, 32'd7);
      wr(A_CNT1, 32'd0);
      set_ab(1, 1);
      set_ab(0, 1);
      set_ab(0, 0);
      set_ab(1, 0);
      set_ab(1, 1);
      rchk("R4 B edges count, A ignored", A_CNT1, 32'd3);
      set_ab(1, 0);
      rchk("R4 B edge down", A_CNT1, 32'd2);

      // R5 unsupported mode holds
      cur_tag = "R5";
      wr(A_MODE1, 32'd9);
      set_ab(0, 0);
      set_ab(0, 1);
      set_ab(1, 1);
      rchk("R5 hold", A_CNT1, 32'd2);

      // R7 compare clear (state 11)
      cur_tag = "R7";
      wr(A_MODE1, 32'd4);
      wr(A_CTL1, 32'd1);
      wr(A_CEIL1, 32'd5);
      wr(A_CNT1, 32'd4);
      qmove_ab(1);
      qmove_ab(1);
      rchk("R7 clear at ceiling", A_CNT1, 32'd0);
      wr(A_CTL1, 32'd0);
      wr(A_CNT1, 32'd5);
      qmove_ab(1);
      rchk("R7 passes ceiling without clear", A_CNT1, 32'd6);
      wr(A_CNT1, 32'hFFFF);
      qmove_ab(1);
      rchk("R7 full-width wrap", A_CNT1, 32'd0);

      // R8 borrow reloads ceiling
      cur_tag = "R8";
      qmove_ab(0);
      rchk("R8 down from zero", A_CNT1, 32'd5);

      // R9 cascade
      cur_tag = "R9";
      wr(A_SHARED, 32'd1);
      wr(A_LCNT, 32'h0000_FFFF);
      qmove_ab(1);
      rchk("R9 carry into high half", A_LCNT, 32'h0001_0000);
      rchk("R9 high half via count 2", A_CNT2, 32'd1);
      qmove_ab(0);
      rchk("R9 borrow from high half", A_LCNT, 32'h0000_FFFF);
      wr(A_CNT1, 32'h1234);
      rchk("R9 16-bit write ignored when joined", A_LCNT, 32'h0000_FFFF);
      wr(A_SHARED, 32'd0);
      wr(A_LCNT, 32'hAAAA_5555);
      rchk("R9 long write ignored when separate", A_LCNT, 32'h0000_FFFF);

      // R10 pair select
      cur_tag = "R10";
      wr(A_SHARED, 32'd2);
      wr(A_CNT1, 32'd0);
      wr(A_CNT2, 32'd0);
      qmove_ab(1);
      qmove_ab(1);
      rchk("R10 ch1 follows A/B", A_CNT1, 32'd2);
      rchk("R10 ch2 ignores A/B", A_CNT2, 32'd0);
      for (int i = 0; i < 3; i++) qmove_cd(1);
      rchk("R10 ch2 follows C/D", A_CNT2, 32'd3);
      rchk("R10 ch1 ignores C/D", A_CNT1, 32'd2);

      // R11 latency (state 01 -> 00 is an up step)
      cur_tag = "R11";
      @(negedge clk);
      enc_a = 1'b0; enc_b = 1'b0;
      bus_addr = A_CNT1;
      rd(A_CNT1, d); check("R11 unchanged after first edge", d, 32'd2);
      rd(A_CNT1, d); check("R11 unchanged after second edge", d, 32'd2);
      rd(A_CNT1, d); check("R11 updated after third edge", d, 32'd3);

      // R12 register readback
      cur_tag = "R12";
      wr(A_MODE2, 32'd7);
      rchk("R12 mode2 readback", A_MODE2, 32'd7);
      wr(A_CEIL2, 32'h1234);
      rchk("R12 ceil2 readback", A_CEIL2, 32'h1234);
      wr(A_CTL2, 32'd1);
      rchk("R12 ctl2 readback", A_CTL2, 32'd1);
      wr(A_LCEIL, 32'h89AB_CDEF);
      rchk("R12 long ceiling readback", A_LCEIL, 32'h89AB_CDEF);
      rchk("R12 unmapped reads zero", 4'd15, 32'd0);

      repeat (2) @(negedge clk);
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule